// File: doc/BRIEF.md
# Byte-Lane Two-Port Register File

This block is the general-purpose register store of a processor datapath. It holds a parameterised set of word-wide registers, 32 entries of 32 bits by default, and serves them through two ports. The first port reads and writes. Its write is split into byte lanes, and each lane has its own enable bit. The second port only reads and never changes the contents.

Both read paths are combinational views of the stored array. A write is committed only on the rising clock edge. During the cycle of a write, both ports still show the register's old contents. The new value appears from the following cycle. There is no forwarding from write data to read data. An active-low reset clears every register to zero and overrides any write attempted while it is held.

Top module: `regfile_2p`

## Requirements
- R1: Port B returns on `b_rdata` the current contents of register `b_addr`. When both addresses are equal, `b_rdata` equals `a_rdata`.
- R2: On a rising clock edge, each set bit i of `a_be` copies `a_wdata[8i+7:8i]` into bits [8i+7:8i] of register `a_addr`.
- R3: On a write, a byte lane whose `a_be` bit is 0 keeps its previous contents.
- R4: `a_rdata` always shows the contents of register `a_addr`, including in cycles where port A is also writing.
- R5: During a write cycle, `a_rdata` shows the value from before the write. The new value is visible from the cycle after the write edge.
- R6: When `a_be` is 4'b0000, no register changes and port A acts as a plain read.
- R7: If port B addresses the register that port A is writing, port B shows the old value in that cycle and the new value in the next cycle.
- R8: While `rst_n` is low, every register reads as zero and writes are ignored. Zero is still read after `rst_n` is released.
- R9: A write changes only register `a_addr`. All other registers keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all writes commit on its rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| a_addr | input | 5 | Port A register index (read and write) |
| a_wdata | input | 32 | Port A write data |
| a_be | input | 4 | Port A byte-lane write enables, bit i for bits [8i+7:8i] |
| a_rdata | output | 32 | Port A read data |
| b_addr | input | 5 | Port B register index (read only) |
| b_rdata | output | 32 | Port B read data |

## Verification
The hardest situation to create is a partial-lane write that both ports observe in the same cycle: port B reads the register being written, and the check must see the old word before the edge and a merged old/new word after it. Directed tasks place each single-lane mask and a zero mask on one register while port B points at it. The checks run before the edge and again one cycle later. A random phase then keeps a small address range, so the two ports often collide. A reference array predicts both read ports every cycle.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned LANE_W = 8;

  function automatic int unsigned lanes_of(input int unsigned width);
    return width / LANE_W;
  endfunction
endpackage

// File: rtl/rf_wr_dec.sv
module rf_wr_dec #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned LANES    = 4,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic [ADDR_W-1:0]               wr_idx,
  input  logic [LANES-1:0]                wr_mask,
  output logic [NUM_REGS-1:0][LANES-1:0]  lane_en
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_row
    logic row_hit;
    assign row_hit    = (wr_idx == ADDR_W'(r));
    assign lane_en[r] = row_hit ? wr_mask : '0;
  end
endmodule

// File: rtl/rf_array.sv
module rf_array
  import rf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned LANES   = DATA_W / LANE_W
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_REGS-1:0][LANES-1:0]     lane_en,
  input  logic [DATA_W-1:0]                  wdata,
  output logic [NUM_REGS-1:0][DATA_W-1:0]    rows
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_row
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] lane_q;
      logic [LANE_W-1:0] lane_d;

      always_comb begin
        lane_d = wdata[l*LANE_W +: LANE_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lane_q <= '0;
        end else if (lane_en[r][l]) begin
          lane_q <= lane_d;
        end
      end

      assign rows[r][l*LANE_W +: LANE_W] = lane_q;
    end
  end
endmodule

// File: rtl/rf_rd_mux.sv
module rf_rd_mux #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] rows,
  input  logic [ADDR_W-1:0]               rd_idx,
  output logic [DATA_W-1:0]               rd_data
);
  always_comb begin
    rd_data = '0;
    for (int unsigned r = 0; r < NUM_REGS; r++) begin
      if (rd_idx == ADDR_W'(r)) rd_data = rows[r];
    end
  end
endmodule

// File: rtl/regfile_2p.sv
module regfile_2p
  import rf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS),
  localparam int unsigned LANES   = lanes_of(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic [LANES-1:0]  a_be,
  output logic [DATA_W-1:0] a_rdata,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_rdata
);
  logic [NUM_REGS-1:0][LANES-1:0]  lane_en;
  logic [NUM_REGS-1:0][DATA_W-1:0] rows;

  rf_wr_dec #(.NUM_REGS(NUM_REGS), .LANES(LANES), .ADDR_W(ADDR_W)) u_dec (
    .wr_idx (a_addr),
    .wr_mask(a_be),
    .lane_en(lane_en)
  );

  rf_array #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_array (
    .clk    (clk),
    .rst_n  (rst_n),
    .lane_en(lane_en),
    .wdata  (a_wdata),
    .rows   (rows)
  );

  rf_rd_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_a (
    .rows   (rows),
    .rd_idx (a_addr),
    .rd_data(a_rdata)
  );

  rf_rd_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_b (
    .rows   (rows),
    .rd_idx (b_addr),
    .rd_data(b_rdata)
  );
endmodule

// File: rtl/rf_checks.sv
module rf_checks #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] a_addr,
  input logic [DATA_W-1:0] a_wdata,
  input logic [LANES-1:0]  a_be,
  input logic [DATA_W-1:0] a_rdata,
  input logic [ADDR_W-1:0] b_addr,
  input logic [DATA_W-1:0] b_rdata
);
  localparam int unsigned LW = DATA_W / LANES;

  AST_SAME_ADDR_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (a_addr == b_addr) |-> (a_rdata == b_rdata)); // R1

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (a_rdata == '0 && b_rdata == '0)); // R8

  AST_ZERO_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (a_be == '0) |=> ($stable(a_addr) -> $stable(a_rdata))); // R6

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    AST_LANE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      a_be[l] |=> ($stable(a_addr) ->
        a_rdata[l*LW +: LW] == $past(a_wdata[l*LW +: LW]))); // R2

    AST_LANE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      !a_be[l] |=> ($stable(a_addr) -> $stable(a_rdata[l*LW +: LW]))); // R3

    AST_B_SEES_NEW: assert property (@(posedge clk) disable iff (!rst_n)
      (a_be[l] && b_addr == a_addr) |=> ($stable(b_addr) ->
        b_rdata[l*LW +: LW] == $past(a_wdata[l*LW +: LW]))); // R7
  end
endmodule

bind regfile_2p rf_checks #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES)) u_checks (
  .clk    (clk),
  .rst_n  (rst_n),
  .a_addr (a_addr),
  .a_wdata(a_wdata),
  .a_be   (a_be),
  .a_rdata(a_rdata),
  .b_addr (b_addr),
  .b_rdata(b_rdata)
);

// File: tb/regfile_2p_tb.sv
`timescale 1ns/1ps
module regfile_2p_tb;
  localparam int NR = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  a_addr, b_addr;
  logic [31:0] a_wdata;
  logic [3:0]  a_be;
  logic [31:0] a_rdata, b_rdata;

  logic [31:0] ref_mem [NR];
  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  regfile_2p u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_be(a_be), .a_rdata(a_rdata),
    .b_addr(b_addr), .b_rdata(b_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] m);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (m[i]) r[i*8 +: 8] = nw[i*8 +: 8];
    return r;
  endfunction

  // Drive at negedge, check old contents before the edge, update model at edge.
  task automatic cyc(input logic [4:0] aa, input logic [31:0] wd, input logic [3:0] be,
                     input logic [4:0] ba, input string tag);
    @(negedge clk);
    a_addr = aa; a_wdata = wd; a_be = be; b_addr = ba;
    #1;
    chk({tag, " R4/R5 port A pre-edge"}, a_rdata, ref_mem[aa]);
    chk({tag, " R1/R7 port B pre-edge"}, b_rdata, ref_mem[ba]);
    @(posedge clk);
    ref_mem[aa] = merge(ref_mem[aa], wd, be);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; a_addr = '0; b_addr = '0; a_wdata = '0; a_be = '0;
    for (int i = 0; i < NR; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R8 reset a", a_rdata, 32'h0);
    chk("R8 reset b", b_rdata, 32'h0);
  endtask

  task automatic t_fill;
    for (int i = 0; i < NR; i++)
      cyc(5'(i), 32'hA5000000 ^ (i * 32'h01010101), 4'hF, 5'(NR - 1 - i), "R2 fill");
    for (int i = 0; i < NR; i++) begin
      @(negedge clk);
      a_be = '0; a_addr = 5'(i); b_addr = 5'(i ^ 5);
      #1;
      chk("R9 readback a", a_rdata, ref_mem[i]);
      chk("R1 readback b", b_rdata, ref_mem[i ^ 5]);
    end
  endtask

  task automatic t_lanes;
    for (int l = 0; l < 4; l++) begin
      cyc(5'd7, 32'h11223344 + l, 4'(1 << l), 5'd7, "R3 single lane");
      @(negedge clk);
      a_be = '0; a_addr = 5'd7; b_addr = 5'd7;
      #1;
      chk("R3 lane merged a", a_rdata, ref_mem[7]);
      chk("R7 lane merged b", b_rdata, ref_mem[7]);
    end
    cyc(5'd9, 32'hDEADBEEF, 4'b1010, 5'd9, "R3 two lanes");
    cyc(5'd9, 32'h0, 4'b0000, 5'd9, "R3 after two lanes");
  endtask

  task automatic t_zero_mask;
    logic [31:0] keep = ref_mem[12];
    cyc(5'd12, 32'hFFFFFFFF, 4'b0000, 5'd12, "R6 zero mask");
    cyc(5'd12, 32'h0, 4'b0000, 5'd3, "R6 after zero mask");
    chk("R6 unchanged model", ref_mem[12], keep);
  endtask

  task automatic t_collision;
    // Back-to-back writes to one register with port B on it.
    cyc(5'd20, 32'h01234567, 4'hF, 5'd20, "R7 collide 1");
    cyc(5'd20, 32'h89ABCDEF, 4'b0110, 5'd20, "R7 collide 2");
    cyc(5'd20, 32'h0, 4'b0000, 5'd20, "R5 collide after");
  endtask

  task automatic t_random;
    for (int k = 0; k < 3000; k++)
      cyc(5'($urandom_range(0, 3) + 4), $urandom, 4'($urandom),
          5'($urandom_range(0, 3) + 4), "R9 random");
    for (int k = 0; k < 1000; k++)
      cyc(5'($urandom), $urandom, 4'($urandom), 5'($urandom), "R2 random wide");
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    a_addr = 5'd4; a_wdata = 32'hCAFEF00D; a_be = 4'hF; b_addr = 5'd5;
    rst_n = 1'b0;
    #1;
    chk("R8 async clear a", a_rdata, 32'h0);
    chk("R8 async clear b", b_rdata, 32'h0);
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1; a_be = '0;
    for (int i = 0; i < NR; i++) ref_mem[i] = '0;
    #1;
    chk("R8 write ignored in reset", a_rdata, 32'h0);
    cyc(5'd4, 32'h0, 4'b0000, 5'd4, "R8 after release");
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  initial begin
    t_reset();
    t_fill();
    t_lanes();
    t_zero_mask();
    t_collision();
    t_random();
    t_reset_mid();
    done = 1'b1;
    summary();
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end
endmodule